// File: doc/BRIEF.md
# Interrupt redirection controller

The block turns a set of external interrupt request lines (24 by default) into interrupt messages bound for processors. Each line owns a 64-bit redirection entry. The entry sets the message vector, the delivery mode, the destination mode, the destination byte, the input polarity, edge or level triggering, and a mask. The block samples the lines and records requests in a pending bitmask. It then issues one message at a time on a valid/ready handshake, taking the lowest-numbered eligible line first.

Software programs the block through an indirect window. A select input chooses one register: the identifier register, a read-only version register, or the low or high word of one redirection entry. A 32-bit write port and a combinational read port then act on the selected register. Two status bits in each entry's low word are maintained by the hardware: a delivery-in-progress flag and a remote request flag. For level-triggered lines, the remote request flag blocks a second delivery until an end-of-interrupt carrying the entry's vector arrives.

Top module: `irq_route`

## Requirements
- R1: After reset, every entry's low word reads 0x00010000, every high word reads 0 and the identifier register reads 0.
- R2: The select map is as follows. 0x00 is the identifier, held in bits 27:24, with all other bits reading 0. 0x01 is the version register, which reads 0x00170011 (highest entry index in bits 23:16, version 0x11 in bits 7:0) and ignores writes. Entry n's low word is at 0x10+2n and its high word at 0x11+2n. Every other select value reads 0.
- R3: Writing an entry's low word stores every bit except bit 12 (delivery status) and bit 14 (remote request), which keep their hardware values. Writing 0xFFFFFFFF to an idle entry therefore reads back 0xFFFFAFFF.
- R4: Writing an entry's high word replaces all 32 bits.
- R5: The effective input is the raw line XOR the polarity bit (bit 13). When the trigger bit (bit 15) is 0, each rising edge of the effective input produces exactly one message. A steady input produces none.
- R6: A line whose mask bit (bit 16) is 1 keeps its request pending without delivering it. Exactly one message follows once the mask is cleared.
- R7: A message carries the vector (low bits 7:0), the delivery mode (bits 10:8), the destination mode (bit 11), the trigger bit (bit 15) and the destination (high bits 31:24). All of these hold steady while valid is high and ready is low.
- R8: When several lines are eligible in the same cycle, the lowest-numbered line is delivered first.
- R9: An entry's bit 12 reads 1 exactly while that line's message waits on the handshake, and 0 otherwise.
- R10: With the trigger bit at 1, the request follows the effective input level. Delivering the message sets remote request (bit 14), and the line is not delivered again while that bit is 1.
- R11: An end-of-interrupt clears remote request on every level-triggered entry whose vector equals the end-of-interrupt vector. A non-matching vector changes nothing. A line whose input is still active is delivered again.
- R12: If a level-triggered line's handshake completes in the same cycle as a matching end-of-interrupt, remote request ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 24 | Raw interrupt request lines |
| sel_i | input | 8 | Register select |
| wr_en_i | input | 1 | Write strobe for the selected register |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data of the selected register |
| eoi_valid_i | input | 1 | End-of-interrupt strobe |
| eoi_vector_i | input | 8 | End-of-interrupt vector |
| msg_valid_o | output | 1 | Message waiting |
| msg_ready_i | input | 1 | Message accepted |
| msg_vector_o | output | 8 | Message vector |
| msg_dlv_mode_o | output | 3 | Message delivery mode |
| msg_dest_mode_o | output | 1 | Message destination mode |
| msg_trig_o | output | 1 | Message trigger mode, 1 for level |
| msg_dest_o | output | 8 | Message destination |

## Verification
Two functions can land on the same clock edge. On that edge a level-triggered line's message handshake completes, which sets remote request, and an end-of-interrupt with the same vector arrives, which clears it. The bench provokes this by holding ready low until the message is waiting, then raising ready and pulsing the matching end-of-interrupt in the same cycle. It judges the result by reading the entry's bit 14 as 1 afterwards and by seeing no second message until another end-of-interrupt is sent. A similar overlap is tested between a software write to a low word and a pending message: the delivery status bit must survive the write.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int unsigned VEC_W   = 8;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned B_DSTAT = 12;
  localparam int unsigned B_POL   = 13;
  localparam int unsigned B_RIRR  = 14;
  localparam int unsigned B_TRIG  = 15;
  localparam int unsigned B_MASK  = 16;
  localparam logic [WORD_W-1:0] LO_WR_KEEP = 32'hFFFF_AFFF;
  localparam logic [7:0] SEL_ID  = 8'h00;
  localparam logic [7:0] SEL_VER = 8'h01;
  localparam logic [7:0] SEL_TBL = 8'h10;

  typedef struct packed {
    logic [VEC_W-1:0] vector;
    logic [2:0]       dlv_mode;
    logic             dest_mode;
    logic             trig;
    logic [7:0]       dest;
  } msg_t;
endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_PINS = 24,
  parameter int unsigned SEL_W    = 8,
  parameter logic [7:0]  VERSION  = 8'h11,
  parameter int unsigned ID_W     = 4,
  parameter int unsigned ID_LSB   = 24,
  localparam int unsigned IDX_W   = $clog2(NUM_PINS)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [SEL_W-1:0]             sel_i,
  input  logic                         wr_en_i,
  input  logic [WORD_W-1:0]            wr_data_i,
  output logic [WORD_W-1:0]            rd_data_o,
  input  logic [NUM_PINS-1:0]          dstat_i,
  input  logic                         hs_i,
  input  logic [IDX_W-1:0]             hs_idx_i,
  input  logic                         eoi_valid_i,
  input  logic [VEC_W-1:0]             eoi_vector_i,
  output logic [NUM_PINS-1:0]          pol_o,
  output logic [NUM_PINS-1:0]          trig_o,
  output logic [NUM_PINS-1:0]          mask_o,
  output logic [NUM_PINS-1:0]          rirr_o,
  output msg_t [NUM_PINS-1:0]          cand_o
);
  localparam logic [SEL_W-1:0] TBL_SPAN = SEL_W'(2 * NUM_PINS);
  localparam logic [WORD_W-1:0] VER_WORD =
    {8'h00, 8'(NUM_PINS - 1), 8'h00, VERSION};

  logic [NUM_PINS-1:0][WORD_W-1:0] lo_q, hi_q, lo_view;
  logic [NUM_PINS-1:0]             rirr_q;
  logic [ID_W-1:0]                 id_q;
  logic [SEL_W-1:0]                tbl_off;
  logic                            tbl_hit;
  logic [IDX_W-1:0]                tbl_idx;

  assign tbl_off = sel_i - SEL_W'(SEL_TBL);
  assign tbl_hit = (sel_i >= SEL_W'(SEL_TBL)) && (tbl_off < TBL_SPAN);
  assign tbl_idx = tbl_off[IDX_W:1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   id_q <= '0;
    else if (wr_en_i && sel_i == SEL_W'(SEL_ID))   id_q <= wr_data_i[ID_LSB +: ID_W];
  end

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_ent
    logic wr_lo, wr_hi, rirr_set, rirr_clr;
    assign wr_lo = wr_en_i && tbl_hit && tbl_idx == IDX_W'(n) && !tbl_off[0];
    assign wr_hi = wr_en_i && tbl_hit && tbl_idx == IDX_W'(n) &&  tbl_off[0];
    assign rirr_set = hs_i && hs_idx_i == IDX_W'(n) && lo_q[n][B_TRIG];
    assign rirr_clr = eoi_valid_i && lo_q[n][B_TRIG] &&
                      lo_q[n][VEC_W-1:0] == eoi_vector_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lo_q[n]   <= 32'h0001_0000;
        hi_q[n]   <= '0;
        rirr_q[n] <= 1'b0;
      end else begin
        if (wr_lo) lo_q[n] <= wr_data_i & LO_WR_KEEP;
        if (wr_hi) hi_q[n] <= wr_data_i;
        if (rirr_set)      rirr_q[n] <= 1'b1;
        else if (rirr_clr) rirr_q[n] <= 1'b0;
      end
    end

    // hardware-owned status bits overlay the stored word (stored as 0)
    assign lo_view[n] = lo_q[n] | (WORD_W'(dstat_i[n]) << B_DSTAT)
                                | (WORD_W'(rirr_q[n])  << B_RIRR);
    assign pol_o[n]  = lo_q[n][B_POL];
    assign trig_o[n] = lo_q[n][B_TRIG];
    assign mask_o[n] = lo_q[n][B_MASK];
    assign rirr_o[n] = rirr_q[n];
    assign cand_o[n] = '{vector:    lo_q[n][7:0],
                         dlv_mode:  lo_q[n][10:8],
                         dest_mode: lo_q[n][11],
                         trig:      lo_q[n][B_TRIG],
                         dest:      hi_q[n][31:24]};

    p_eoi_clears_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rirr_clr && !(hs_i && hs_idx_i == IDX_W'(n))) |=> !rirr_o[n]);
  end

  always_comb begin
    rd_data_o = '0;
    if (sel_i == SEL_W'(SEL_ID))       rd_data_o[ID_LSB +: ID_W] = id_q;
    else if (sel_i == SEL_W'(SEL_VER)) rd_data_o = VER_WORD;
    else if (tbl_hit)                  rd_data_o = tbl_off[0] ? hi_q[tbl_idx] : lo_view[tbl_idx];
  end

  p_dstat_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dstat_i));

  p_ro_bits_kept_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && tbl_hit && !tbl_off[0] && !hs_i && !eoi_valid_i) |=> $stable(rirr_o));
endmodule

// File: rtl/irq_route_pend.sv
module irq_route_pend #(
  parameter int unsigned NUM_PINS = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] irq_i,
  input  logic [NUM_PINS-1:0] pol_i,
  input  logic [NUM_PINS-1:0] trig_i,
  input  logic [NUM_PINS-1:0] clr_i,
  output logic [NUM_PINS-1:0] pend_o
);
  logic [NUM_PINS-1:0] eff, eff_q, pend_q;

  assign eff = irq_i ^ pol_i;

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        eff_q[n]  <= 1'b0;
        pend_q[n] <= 1'b0;
      end else begin
        eff_q[n] <= eff[n];
        // level: request mirrors input; edge: sticky, new edge beats clear
        if (trig_i[n]) pend_q[n] <= eff[n];
        else           pend_q[n] <= (pend_q[n] & ~clr_i[n]) | (eff[n] & ~eff_q[n]);
      end
    end

    p_edge_sets_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!trig_i[n] && eff[n] && !eff_q[n]) |=> pend_o[n]);
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_route_arb.sv
module irq_route_arb
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_PINS = 24,
  localparam int unsigned IDX_W   = $clog2(NUM_PINS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] elig_i,
  input  msg_t [NUM_PINS-1:0] cand_i,
  input  logic                ready_i,
  output logic                valid_o,
  output msg_t                msg_o,
  output logic [IDX_W-1:0]    idx_o,
  output logic [NUM_PINS-1:0] dstat_o
);
  logic [IDX_W-1:0] pick, idx_q;
  logic             valid_q;
  msg_t             msg_q;

  always_comb begin
    pick = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--)
      if (elig_i[i]) pick = IDX_W'(i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      idx_q   <= '0;
      msg_q   <= '0;
    end else if (!valid_q) begin
      if (|elig_i) begin
        valid_q <= 1'b1;
        idx_q   <= pick;
        msg_q   <= cand_i[pick];
      end
    end else if (ready_i) begin
      valid_q <= 1'b0;
    end
  end

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_ds
    assign dstat_o[n] = valid_q && idx_q == IDX_W'(n);
  end

  assign valid_o = valid_q;
  assign msg_o   = msg_q;
  assign idx_o   = idx_q;

  p_hold_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(msg_o) && $stable(idx_o)));

  p_pick_unmasked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> |($past(elig_i) & dstat_o));
endmodule

// File: rtl/irq_route.sv
module irq_route
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_PINS = 24,
  parameter int unsigned SEL_W    = 8,
  parameter logic [7:0]  VERSION  = 8'h11,
  localparam int unsigned IDX_W   = $clog2(NUM_PINS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] irq_i,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic                wr_en_i,
  input  logic [31:0]         wr_data_i,
  output logic [31:0]         rd_data_o,
  input  logic                eoi_valid_i,
  input  logic [7:0]          eoi_vector_i,
  output logic                msg_valid_o,
  input  logic                msg_ready_i,
  output logic [7:0]          msg_vector_o,
  output logic [2:0]          msg_dlv_mode_o,
  output logic                msg_dest_mode_o,
  output logic                msg_trig_o,
  output logic [7:0]          msg_dest_o
);
  logic [NUM_PINS-1:0] pol, trig, mask, rirr, pend, elig, dstat, clr;
  msg_t [NUM_PINS-1:0] cand;
  msg_t                msg;
  logic [IDX_W-1:0]    idx;
  logic                hs;

  assign hs = msg_valid_o && msg_ready_i;

  irq_route_regs #(
    .NUM_PINS(NUM_PINS), .SEL_W(SEL_W), .VERSION(VERSION), .ID_W(4), .ID_LSB(24)
  ) u_regs (
    .clk_i, .rst_ni, .sel_i, .wr_en_i, .wr_data_i, .rd_data_o,
    .dstat_i(dstat), .hs_i(hs), .hs_idx_i(idx),
    .eoi_valid_i, .eoi_vector_i,
    .pol_o(pol), .trig_o(trig), .mask_o(mask), .rirr_o(rirr), .cand_o(cand)
  );

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_clr
    assign clr[n] = hs && idx == IDX_W'(n);
  end

  irq_route_pend #(.NUM_PINS(NUM_PINS)) u_pend (
    .clk_i, .rst_ni, .irq_i, .pol_i(pol), .trig_i(trig), .clr_i(clr), .pend_o(pend)
  );

  assign elig = pend & ~mask & ~(trig & rirr);

  irq_route_arb #(.NUM_PINS(NUM_PINS)) u_arb (
    .clk_i, .rst_ni, .elig_i(elig), .cand_i(cand), .ready_i(msg_ready_i),
    .valid_o(msg_valid_o), .msg_o(msg), .idx_o(idx), .dstat_o(dstat)
  );

  assign msg_vector_o    = msg.vector;
  assign msg_dlv_mode_o  = msg.dlv_mode;
  assign msg_dest_mode_o = msg.dest_mode;
  assign msg_trig_o      = msg.trig;
  assign msg_dest_o      = msg.dest;

  p_no_redeliver_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs && msg_trig_o) |-> !rirr[idx]);
endmodule

// File: tb/irq_route_test.sv
module irq_route_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 24;
  localparam int WD_CYCLES = 50000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [NP-1:0] irq = '0;
  logic [7:0] sel = '0;
  logic wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic eoi_valid = 1'b0;
  logic [7:0] eoi_vector = '0;
  logic msg_valid, msg_ready = 1'b1;
  logic [7:0] msg_vector, msg_dest;
  logic [2:0] msg_dlv;
  logic msg_dm, msg_trig;

  int n_chk = 0, n_fail = 0, msg_n = 0;
  bit done = 0;
  logic [7:0] log_vec [256];
  logic [7:0] log_dest [256];
  logic [2:0] log_dlv [256];
  logic log_dm [256];
  logic log_trig [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_route uut (
    .clk_i(clk), .rst_ni(rst_ni), .irq_i(irq), .sel_i(sel), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rd_data_o(rd_data), .eoi_valid_i(eoi_valid),
    .eoi_vector_i(eoi_vector), .msg_valid_o(msg_valid), .msg_ready_i(msg_ready),
    .msg_vector_o(msg_vector), .msg_dlv_mode_o(msg_dlv), .msg_dest_mode_o(msg_dm),
    .msg_trig_o(msg_trig), .msg_dest_o(msg_dest)
  );

  // inputs only change at posedge+1, so a negedge sample sees each handshake once
  always @(negedge clk) begin
    if (rst_ni && msg_valid && msg_ready && msg_n < 256) begin
      log_vec[msg_n] = msg_vector; log_dest[msg_n] = msg_dest;
      log_dlv[msg_n] = msg_dlv; log_dm[msg_n] = msg_dm; log_trig[msg_n] = msg_trig;
      msg_n++;
    end
  end

  task automatic tick(input int k = 1);
    repeat (k) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] s, input logic [31:0] d);
    sel = s; wr_data = d; wr_en = 1'b1;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] s, input logic [31:0] exp, input string tag);
    sel = s;
    @(negedge clk);
    chk(rd_data === exp, tag, rd_data, exp);
    tick();
  endtask

  task automatic eoi(input logic [7:0] v);
    eoi_vector = v; eoi_valid = 1'b1;
    tick();
    eoi_valid = 1'b0;
  endtask

  function automatic logic [31:0] lo_w(input logic [7:0] v, input logic [2:0] dlv,
      input logic dm, input logic pol, input logic lvl, input logic msk);
    return {15'd0, msk, lvl, 1'b0, pol, 1'b0, dm, dlv, v};
  endfunction

  function automatic logic [7:0] lo_sel(input int n);
    return 8'(16 + 2 * n);
  endfunction

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", WD_CYCLES, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int base;
    tick(3);
    rst_ni = 1'b1;
    tick();

    // R1 reset state
    for (int n = 0; n < NP; n++) begin
      rd_chk(lo_sel(n), 32'h0001_0000, "R1 low word after reset");
      rd_chk(lo_sel(n) + 8'd1, 32'h0, "R1 high word after reset");
    end
    rd_chk(8'h00, 32'h0, "R1 id after reset");

    // R2 select map
    rd_chk(8'h01, 32'h0017_0011, "R2 version");
    wr_reg(8'h01, 32'hFFFF_FFFF);
    rd_chk(8'h01, 32'h0017_0011, "R2 version ignores write");
    wr_reg(8'h00, 32'hFFFF_FFFF);
    rd_chk(8'h00, 32'h0F00_0000, "R2 id field only");
    for (int s = 2; s < 16; s++) rd_chk(8'(s), 32'h0, "R2 unused low select");
    for (int s = 16 + 2 * NP; s < 256; s += 7) rd_chk(8'(s), 32'h0, "R2 unused high select");

    // R4 high word
    wr_reg(8'h11, 32'hA5C3_1234);
    rd_chk(8'h11, 32'hA5C3_1234, "R4 high word full replace");
    wr_reg(8'h11, 32'h0);

    // R3 low word read-only bits on an idle, masked entry
    wr_reg(8'h10, 32'hFFFF_FFFF);
    rd_chk(8'h10, 32'hFFFF_AFFF, "R3 low word all ones");
    wr_reg(8'h10, 32'h0001_0000);
    tick(3);
    chk(msg_n == 0, "R6 no message while masked", msg_n, 0);

    // R5/R7 edge sweep over every pin with varied fields
    for (int n = 0; n < NP; n++) begin
      base = msg_n;
      wr_reg(lo_sel(n) + 8'd1, {8'(8'h40 + n), 24'h0});
      wr_reg(lo_sel(n), lo_w(8'(8'h20 + n), 3'(n % 8), 1'(n % 2), 1'b0, 1'b0, 1'b0));
      irq[n] = 1'b1;
      tick(3);
      irq[n] = 1'b0;
      tick(6);
      chk(msg_n == base + 1, "R5 one message per edge", msg_n, base + 1);
      chk(log_vec[base] == 8'(8'h20 + n), "R7 vector", log_vec[base], 8'(8'h20 + n));
      chk(log_dest[base] == 8'(8'h40 + n), "R7 destination", log_dest[base], 8'(8'h40 + n));
      chk({log_dlv[base], log_dm[base], log_trig[base]} == {3'(n % 8), 1'(n % 2), 1'b0},
          "R7 mode fields", {log_dlv[base], log_dm[base], log_trig[base]},
          {3'(n % 8), 1'(n % 2), 1'b0});
      wr_reg(lo_sel(n), lo_w(8'(8'h20 + n), 3'(n % 8), 1'(n % 2), 1'b0, 1'b0, 1'b1));
    end

    // R6 masked pending, then unmask
    base = msg_n;
    irq[3] = 1'b1; tick(); irq[3] = 1'b0;
    tick(6);
    chk(msg_n == base, "R6 masked pin not delivered", msg_n, base);
    wr_reg(lo_sel(3), lo_w(8'h23, 3'd3, 1'b1, 1'b0, 1'b0, 1'b0));
    tick(6);
    chk(msg_n == base + 1, "R6 delivered after unmask", msg_n, base + 1);
    chk(log_vec[base] == 8'h23, "R6 unmasked vector", log_vec[base], 8'h23);
    wr_reg(lo_sel(3), lo_w(8'h23, 3'd3, 1'b1, 1'b0, 1'b0, 1'b1));

    // R5 inverted polarity: raw falling edge is the effective rising edge
    base = msg_n;
    wr_reg(lo_sel(6), lo_w(8'h26, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0));
    irq[6] = 1'b1;
    tick(6);
    chk(msg_n == base, "R5 inverted polarity raw rise ignored", msg_n, base);
    irq[6] = 1'b0;
    tick(6);
    chk(msg_n == base + 1, "R5 inverted polarity raw fall delivers", msg_n, base + 1);
    chk(log_vec[base] == 8'h26, "R5 inverted polarity vector", log_vec[base], 8'h26);
    wr_reg(lo_sel(6), lo_w(8'h26, 3'd0, 1'b0, 1'b1, 1'b0, 1'b1));

    // R8/R9/R3 priority with ready held low
    base = msg_n;
    msg_ready = 1'b0;
    wr_reg(lo_sel(7), lo_w(8'h27, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0));
    wr_reg(lo_sel(2), lo_w(8'h22, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0));
    irq[2] = 1'b1; irq[7] = 1'b1;
    tick();
    irq[2] = 1'b0; irq[7] = 1'b0;
    tick(4);
    @(negedge clk);
    chk(msg_valid && msg_vector == 8'h22, "R8 lowest pin presented first", msg_vector, 8'h22);
    tick(3);
    @(negedge clk);
    chk(msg_valid && msg_vector == 8'h22, "R7 message held while not ready", msg_vector, 8'h22);
    tick();
    rd_chk(lo_sel(2), lo_w(8'h22, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0) | 32'h1000, "R9 status set while waiting");
    rd_chk(lo_sel(7), lo_w(8'h27, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0), "R9 status clear for queued pin");
    wr_reg(lo_sel(2), lo_w(8'h22, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0) | 32'h4000);
    rd_chk(lo_sel(2), lo_w(8'h22, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0) | 32'h1000, "R3 write keeps status bits");
    msg_ready = 1'b1;
    tick(8);
    chk(msg_n == base + 2, "R8 both delivered", msg_n, base + 2);
    chk(log_vec[base] == 8'h22 && log_vec[base + 1] == 8'h27, "R8 order low then high",
        {log_vec[base], log_vec[base + 1]}, {8'h22, 8'h27});
    rd_chk(lo_sel(2), lo_w(8'h22, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0), "R9 status clear after handshake");
    wr_reg(lo_sel(2), lo_w(8'h22, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1));
    wr_reg(lo_sel(7), lo_w(8'h27, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1));

    // R10/R11 level trigger and remote request
    base = msg_n;
    wr_reg(lo_sel(9) + 8'd1, 32'h9900_0000);
    wr_reg(lo_sel(9), lo_w(8'h59, 3'd1, 1'b0, 1'b0, 1'b1, 1'b0));
    irq[9] = 1'b1;
    tick(6);
    chk(msg_n == base + 1, "R10 level first delivery", msg_n, base + 1);
    chk(log_trig[base] == 1'b1 && log_dest[base] == 8'h99, "R7 level message fields",
        {log_trig[base], log_dest[base]}, {1'b1, 8'h99});
    rd_chk(lo_sel(9), lo_w(8'h59, 3'd1, 1'b0, 1'b0, 1'b1, 1'b0) | 32'h4000, "R10 remote request set");
    tick(10);
    chk(msg_n == base + 1, "R10 no redelivery while remote request", msg_n, base + 1);
    eoi(8'h5A);
    tick(6);
    chk(msg_n == base + 1, "R11 non-matching eoi ignored", msg_n, base + 1);
    rd_chk(lo_sel(9), lo_w(8'h59, 3'd1, 1'b0, 1'b0, 1'b1, 1'b0) | 32'h4000, "R11 remote request kept");
    eoi(8'h59);
    tick(6);
    chk(msg_n == base + 2, "R11 matching eoi redelivers active line", msg_n, base + 2);
    irq[9] = 1'b0;
    tick(2);
    eoi(8'h59);
    tick(6);
    chk(msg_n == base + 2, "R11 inactive line not redelivered", msg_n, base + 2);
    rd_chk(lo_sel(9), lo_w(8'h59, 3'd1, 1'b0, 1'b0, 1'b1, 1'b0), "R11 remote request cleared");
    wr_reg(lo_sel(9), lo_w(8'h59, 3'd1, 1'b0, 1'b0, 1'b1, 1'b1));

    // R12 handshake and matching eoi in the same cycle
    base = msg_n;
    msg_ready = 1'b0;
    wr_reg(lo_sel(11) + 8'd1, 32'hBB00_0000);
    wr_reg(lo_sel(11), lo_w(8'h6B, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0));
    irq[11] = 1'b1;
    tick(5);
    @(negedge clk);
    chk(msg_valid && msg_vector == 8'h6B, "R12 level message waiting", msg_vector, 8'h6B);
    tick();
    msg_ready = 1'b1; eoi_vector = 8'h6B; eoi_valid = 1'b1;
    tick();
    eoi_valid = 1'b0;
    tick(10);
    chk(msg_n == base + 1, "R12 no redelivery after coincident eoi", msg_n, base + 1);
    rd_chk(lo_sel(11), lo_w(8'h6B, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0) | 32'h4000, "R12 remote request set wins");
    eoi(8'h6B);
    tick(6);
    chk(msg_n == base + 2, "R12 later eoi redelivers", msg_n, base + 2);
    irq[11] = 1'b0;
    tick(2);
    eoi(8'h6B);
    tick(4);
    rd_chk(lo_sel(11), lo_w(8'h6B, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0), "R11 cleared after final eoi");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule